// File: doc/BRIEF.md
# Color Channel Sampling Sequencer

This block picks which of three color inputs (red, green, blue) the sampling path converts next. It runs in one of three patterns: a full rotation over all three colors, an alternation between two chosen colors, or a fixed single color. Its outputs are a one-hot select, a sample-valid pulse and a 2-bit tag that names the color of each sample taken.

A sample strobe moves the sequence on by one step. A rising edge on the line-sync input (the data-clock rising edge of the sampling front end) restarts the sequence at its first color. On that same edge the block also loads the mode, order and enable settings from its configuration inputs. Between such edges, changes to the configuration inputs are held back. A configuration that names no color, or names all three without selecting full rotation, falls back to red only and raises an error flag.

Top module: `chan_seq_gen`

## Requirements
- R1: In rotation mode (`cfg_tri`=1) with `cfg_fwd`=1, each accepted strobe moves the select red -> green -> blue -> red. The select bits are `sel[0]` red, `sel[1]` green and `sel[2]` blue.
- R2: In rotation mode with `cfg_fwd`=0, each accepted strobe moves the select blue -> green -> red -> blue.
- R3: The cycle after a rising edge of `sync_in`, the select shows the first color of the newly loaded setting: red for forward rotation, blue for reverse rotation. Holding `sync_in` high does not restart the sequence again.
- R4: Changes to `cfg_tri`, `cfg_fwd` and `cfg_en` have no effect on the select or on `cfg_err` until the next rising edge of `sync_in`.
- R5: With `cfg_tri`=0 and exactly two bits of `cfg_en` set (bit 0 red, bit 1 green, bit 2 blue), the select alternates between those two colors. It starts at the lower-numbered one when `cfg_fwd`=1 and at the higher-numbered one when `cfg_fwd`=0.
- R6: With `cfg_tri`=0 and exactly one bit of `cfg_en` set, the select stays on that color for every strobe.
- R7: With `cfg_tri`=0 and zero or three bits of `cfg_en` set, the select stays on red and `cfg_err` is 1.
- R8: With `cfg_tri`=1, `cfg_en` is ignored (even all zeros) and `cfg_err` is 0.
- R9: One cycle after an accepted strobe, `smp_vld` is 1 and `smp_tag` gives the color that was selected when the strobe was taken (0 red, 1 green, 2 blue). Otherwise `smp_vld` is 0.
- R10: A strobe in the same cycle as a `sync_in` rising edge is dropped: no `smp_vld` follows it, and the select shows the first color.
- R11: After reset the select is red, `smp_vld` and `cfg_err` are 0, and the loaded setting is forward rotation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_tri | input | 1 | 1 selects three-color rotation |
| cfg_fwd | input | 1 | Order: 1 forward (red first), 0 reverse |
| cfg_en | input | 3 | Color enables: bit0 red, bit1 green, bit2 blue |
| sync_in | input | 1 | Line sync; a rising edge restarts the sequence and loads the settings |
| strobe | input | 1 | Sample strobe; moves the sequence one step |
| sel | output | 3 | One-hot color select |
| smp_vld | output | 1 | Pulses one cycle after each accepted strobe |
| smp_tag | output | 2 | Color code of the last sample taken |
| cfg_err | output | 1 | The loaded setting is invalid; the select is forced to red |

## Verification
A corrupted position register shows up on `sel` in the same cycle, and on `smp_tag` one cycle after the next strobe. The bench therefore checks the select after every step and the tag after every strobe. A corrupted loaded setting only becomes visible when a strobe tries to move the sequence, so every mode is followed through at least one full cycle of its pattern. A missed or repeated restart shows up as the wrong first color right after a sync edge, which the bench checks with the sync line both pulsed and held high.

// File: rtl/chan_seq_gen.sv
module chan_seq_gen #(
  parameter int NCOL = 3,
  localparam int TW  = $clog2(NCOL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_tri,
  input  logic            cfg_fwd,
  input  logic [NCOL-1:0] cfg_en,
  input  logic            sync_in,
  input  logic            strobe,
  output logic [NCOL-1:0] sel,
  output logic            smp_vld,
  output logic [TW-1:0]   smp_tag,
  output logic            cfg_err
);

  logic            sync_q;
  logic            sh_tri, sh_fwd;
  logic [NCOL-1:0] sh_en;
  logic [NCOL-1:0] sel_q;

  wire sync_rise = sync_in & ~sync_q;

  function automatic logic [1:0] ones3(input logic [2:0] e);
    return 2'(e[0]) + 2'(e[1]) + 2'(e[2]);
  endfunction

  function automatic logic [2:0] first_of(input logic t, input logic f, input logic [2:0] e);
    logic [1:0] n;
    n = ones3(e);
    if (t)           return f ? 3'b001 : 3'b100;
    else if (n == 1) return e;
    else if (n == 2) return f ? (e & (~e + 3'd1)) : (e[2] ? 3'b100 : 3'b010);
    else             return 3'b001;
  endfunction

  logic [2:0] sel_nx;
  always_comb begin
    if (sh_tri)
      sel_nx = sh_fwd ? {sel_q[1:0], sel_q[2]} : {sel_q[0], sel_q[2:1]};
    else if (ones3(sh_en) == 2)
      sel_nx = sh_en & ~sel_q;
    else
      sel_nx = sel_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b1;
      sh_tri  <= 1'b1;
      sh_fwd  <= 1'b1;
      sh_en   <= 3'b001;
      sel_q   <= 3'b001;
      smp_vld <= 1'b0;
      smp_tag <= '0;
    end else begin
      sync_q  <= sync_in;
      smp_vld <= 1'b0;
      if (sync_rise) begin
        sh_tri <= cfg_tri;
        sh_fwd <= cfg_fwd;
        sh_en  <= cfg_en;
        sel_q  <= first_of(cfg_tri, cfg_fwd, cfg_en);
      end else if (strobe) begin
        smp_vld <= 1'b1;
        smp_tag <= sel_q[2] ? 2'd2 : (sel_q[1] ? 2'd1 : 2'd0);
        sel_q   <= sel_nx;
      end
    end
  end

  assign sel     = sel_q;
  assign cfg_err = ~sh_tri & ((ones3(sh_en) == 0) | (ones3(sh_en) == 3));

endmodule

// File: rtl/chan_seq_gen_chk.sv
module chan_seq_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cfg_tri,
  input logic       cfg_fwd,
  input logic       sync_in,
  input logic       sync_q,
  input logic       strobe,
  input logic       sh_tri,
  input logic       sh_fwd,
  input logic [2:0] sh_en,
  input logic [2:0] sel,
  input logic       smp_vld,
  input logic [1:0] smp_tag,
  input logic       cfg_err
);

  a_r1_fwd_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !(sync_in && !sync_q) && sh_tri && sh_fwd && sel == 3'b001) |=> sel == 3'b010);

  a_r2_rev_step: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !(sync_in && !sync_q) && sh_tri && !sh_fwd && sel == 3'b100) |=> sel == 3'b010);

  a_r3_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !sync_q && cfg_tri) |=> sel == (cfg_fwd ? 3'b001 : 3'b100)) ;

  a_r3_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(sel) == 1);

  a_r6_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !(sync_in && !sync_q) && !sh_tri && $countones(sh_en) == 1) |=> $stable(sel));

  a_r7_err_red: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> sel == 3'b001);

  a_r9_tag_match: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !(sync_in && !sync_q)) |=> (smp_vld && (3'b001 << smp_tag) == $past(sel)));

  a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_in && !sync_q) |=> !smp_vld);

endmodule

bind chan_seq_gen chan_seq_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_tri(cfg_tri), .cfg_fwd(cfg_fwd),
  .sync_in(sync_in), .sync_q(sync_q), .strobe(strobe),
  .sh_tri(sh_tri), .sh_fwd(sh_fwd), .sh_en(sh_en),
  .sel(sel), .smp_vld(smp_vld), .smp_tag(smp_tag), .cfg_err(cfg_err)
);

// File: tb/chan_seq_gen_bench.sv
module chan_seq_gen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_tri = 1'b1, cfg_fwd = 1'b1, sync_in = 1'b0, strobe = 1'b0;
  logic [2:0] cfg_en = 3'b000;
  logic [2:0] sel;
  logic smp_vld, cfg_err;
  logic [1:0] smp_tag;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  chan_seq_gen u_chan_seq_gen (
    .clk(clk), .rst_n(rst_n), .cfg_tri(cfg_tri), .cfg_fwd(cfg_fwd), .cfg_en(cfg_en),
    .sync_in(sync_in), .strobe(strobe), .sel(sel), .smp_vld(smp_vld),
    .smp_tag(smp_tag), .cfg_err(cfg_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // one strobe; check tag of the sampled color and the new select
  task automatic step(input string req, input int tag_exp, input int sel_exp);
    strobe = 1'b1;
    @(negedge clk);
    strobe = 1'b0;
    chk({req, " vld"}, smp_vld, 1);
    chk({req, " tag"}, smp_tag, tag_exp);
    chk({req, " sel"}, sel, sel_exp);
  endtask

  task automatic resync(input logic t, input logic f, input logic [2:0] e);
    cfg_tri = t; cfg_fwd = f; cfg_en = e;
    sync_in = 1'b1;
    @(negedge clk);
    sync_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R11 sel", sel, 3'b001);
    chk("R11 vld", smp_vld, 0);
    chk("R11 err", cfg_err, 0);
    step("R11 default fwd", 0, 3'b010);
  endtask

  task automatic t_fwd;
    resync(1, 1, 3'b000);
    chk("R3 first fwd", sel, 3'b001);
    step("R1 r->g", 0, 3'b010);
    step("R1 g->b", 1, 3'b100);
    step("R1 b->r", 2, 3'b001);
  endtask

  task automatic t_rev;
    resync(1, 0, 3'b000);
    chk("R3 first rev", sel, 3'b100);
    chk("R8 no err", cfg_err, 0);
    step("R2 b->g", 2, 3'b010);
    step("R2 g->r", 1, 3'b001);
    step("R2 r->b", 0, 3'b100);
  endtask

  task automatic t_hold_cfg;
    resync(1, 1, 3'b000);
    cfg_tri = 1'b0; cfg_en = 3'b000;
    @(negedge clk);
    chk("R4 err unchanged", cfg_err, 0);
    step("R4 still rotating", 0, 3'b010);
    step("R4 still rotating 2", 1, 3'b100);
  endtask

  task automatic t_single;
    resync(0, 1, 3'b010);
    chk("R6 green", sel, 3'b010);
    for (int i = 0; i < 3; i++) step("R6 hold", 1, 3'b010);
    chk("R6 no err", cfg_err, 0);
  endtask

  task automatic t_pair;
    resync(0, 1, 3'b101);
    chk("R5 fwd first red", sel, 3'b001);
    step("R5 r->b", 0, 3'b100);
    step("R5 b->r", 2, 3'b001);
    resync(0, 0, 3'b101);
    chk("R5 rev first blue", sel, 3'b100);
    step("R5 rev b->r", 2, 3'b001);
    resync(0, 1, 3'b110);
    chk("R5 gb first green", sel, 3'b010);
    step("R5 g->b", 1, 3'b100);
    step("R5 b->g", 2, 3'b010);
  endtask

  task automatic t_err;
    resync(0, 0, 3'b000);
    chk("R7 err none", cfg_err, 1);
    chk("R7 red none", sel, 3'b001);
    step("R7 hold red", 0, 3'b001);
    resync(0, 1, 3'b111);
    chk("R7 err all", cfg_err, 1);
    step("R7 hold red all", 0, 3'b001);
    resync(1, 1, 3'b111);
    chk("R8 all enables ok", cfg_err, 0);
  endtask

  task automatic t_sync_held;
    resync(1, 1, 3'b000);
    step("R3 pre", 0, 3'b010);
    step("R3 pre2", 1, 3'b100);
    cfg_tri = 1'b1; cfg_fwd = 1'b1;
    sync_in = 1'b1;
    @(negedge clk);
    chk("R3 restart", sel, 3'b001);
    step("R3 held no restart", 0, 3'b010);
    step("R3 held no restart 2", 1, 3'b100);
    sync_in = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_collide;
    resync(1, 1, 3'b000);
    step("R10 pre", 0, 3'b010);
    cfg_fwd = 1'b0;
    sync_in = 1'b1; strobe = 1'b1;
    @(negedge clk);
    sync_in = 1'b0; strobe = 1'b0;
    chk("R10 no vld", smp_vld, 0);
    chk("R10 first color", sel, 3'b100);
    @(negedge clk);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fwd();
    t_rev();
    t_hold_cfg();
    t_single();
    t_pair();
    t_err();
    t_sync_held();
    t_collide();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule